// File: doc/BRIEF.md
# Receive FIFO Auto-RTS Flow Controller

This block drives the active-low request-to-send pin of a serial port's receive side. It watches the fill level of a 64-entry receive FIFO. When the FIFO gets close to full, it tells the remote transmitter to pause. When the FIFO has drained, it lets the transmitter resume. Two thresholds, one high and one low, come from the selected receive trigger level. Between them the block holds its last decision, which gives hysteresis and keeps the pin from chattering near a single boundary.

Automatic control is armed by a flow-control enable. It only takes effect once software also sets its request-to-send bit, which first drives the pin low. With automatic control off, the pin simply follows that software bit.

Each low-to-high transition of the pin under automatic control sets a status flag. A status-read strobe clears the flag. An interrupt request follows the flag when its enable is set. That enable can only be written while enhanced functions are unlocked.

Top module: `rx_rts_flow`

## Requirements
- R1: After reset, `rts_n` is 1 (with `rts_req`=0), `rts_flag` is 0, `rts_irq` is 0, the hold state is cleared and the interrupt enable is 0.
- R2: With `auto_en`=0, `rts_n` equals the inverse of `rts_req` in the same cycle, whatever the FIFO level.
- R3: With `auto_en`=1 and `rts_req`=0, `rts_n` stays 1 at every FIFO level; automatic control starts only when `rts_req` is 1.
- R4: With `auto_en`=1 and `rts_req`=1, a level strictly above the high threshold drives `rts_n` to 1 after the next clock edge.
- R5: With automatic control active, a level strictly below the low threshold drives `rts_n` to 0 after the next clock edge.
- R6: With automatic control active, a level from the low threshold to the high threshold, inclusive, leaves `rts_n` unchanged.
- R7: `trig_sel` selects the trigger level: 00 selects 8, 01 selects 16, 10 selects 56 and 11 selects 60. The low threshold is trigger/2 and the high threshold is 64 − trigger/2, so trigger 16 gives 8 and 56.
- R8: A low-to-high transition of `rts_n` while `auto_en`=1 sets `rts_flag` at the following clock edge.
- R9: `stat_rd` clears `rts_flag` at the clock edge. A new set in the same cycle wins over the clear.
- R10: `ier_wr` loads `ier_rts` into the interrupt enable only while `ext_en`=1, and otherwise has no effect. `rts_irq` is `rts_flag` AND the enable.
- R11: While automatic control is inactive (`auto_en`=0 or `rts_req`=0), the hold state clears. Re-arming therefore always starts with `rts_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | 7 | Current receive FIFO occupancy, 0 to 64 |
| trig_sel | input | 2 | Receive trigger level select |
| auto_en | input | 1 | Automatic RTS flow-control enable |
| rts_req | input | 1 | Software request-to-send bit |
| ext_en | input | 1 | Enhanced-function unlock; gates the enable write |
| ier_wr | input | 1 | Write strobe for the RTS interrupt enable |
| ier_rts | input | 1 | Value written into the RTS interrupt enable |
| stat_rd | input | 1 | Status-read strobe that clears the flag |
| rts_n | output | 1 | Active-low request-to-send pin |
| rts_flag | output | 1 | RTS transition status flag |
| rts_irq | output | 1 | RTS interrupt request |

## Verification
The bench pushes the level exactly onto each threshold and one step past it, for all four trigger selections. A comparison written with >= instead of >, or a wrong threshold table, would flip `rts_n` one entry early or not at all.

It also drops `rts_req` and `auto_en` while the pin is halted, then re-arms. A design that kept the stale hold state would come back with `rts_n` high.

Strobes collide on purpose. A status read lands in the same cycle as a new rising edge, where a design that lets the clear win would lose the event. Enable writes are also issued while `ext_en` is locked, where a leaky enable would raise `rts_irq` on the next transition.

// File: rtl/rx_rts_flow.sv
module rx_rts_flow #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fifo_level,
  input  logic [1:0]    trig_sel,
  input  logic          auto_en,
  input  logic          rts_req,
  input  logic          ext_en,
  input  logic          ier_wr,
  input  logic          ier_rts,
  input  logic          stat_rd,
  output logic          rts_n,
  output logic          rts_flag,
  output logic          rts_irq
);

  localparam logic [CW-1:0] TRIG0 = CW'(DEPTH / 8);
  localparam logic [CW-1:0] TRIG1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] TRIG2 = CW'(DEPTH - 8);
  localparam logic [CW-1:0] TRIG3 = CW'(DEPTH - 4);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);

  logic [CW-1:0] trig, lo_thr, hi_thr;
  logic          active, halt, rts_n_q, irq_en, rise;

  always_comb begin
    case (trig_sel)
      2'd0:    trig = TRIG0;
      2'd1:    trig = TRIG1;
      2'd2:    trig = TRIG2;
      default: trig = TRIG3;
    endcase
  end

  assign lo_thr = trig >> 1;
  assign hi_thr = FULL - lo_thr;
  assign active = auto_en & rts_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   halt <= 1'b0;
    else if (!active)             halt <= 1'b0;
    else if (fifo_level > hi_thr) halt <= 1'b1;
    else if (fifo_level < lo_thr) halt <= 1'b0;
  end

  assign rts_n = ~rts_req | (auto_en & halt);
  assign rise  = auto_en & rts_n & ~rts_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n_q  <= 1'b1;
      rts_flag <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      rts_n_q <= rts_n;
      if (rise)         rts_flag <= 1'b1;
      else if (stat_rd) rts_flag <= 1'b0;
      if (ier_wr && ext_en) irq_en <= ier_rts;
    end
  end

  assign rts_irq = rts_flag & irq_en;

  // R4
  halt_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && fifo_level > hi_thr |=> halt);
  // R5
  resume_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && fifo_level < lo_thr |=> !halt);
  // R6
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && fifo_level >= lo_thr && fifo_level <= hi_thr |=> halt == $past(halt));
  // R11
  inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !halt);
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && rts_n && !rts_n_q |=> rts_flag);
  // R9
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_flag) |-> $past(stat_rd));
  // R10
  enable_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |=> irq_en == $past(irq_en));
  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_irq |-> rts_flag);

endmodule

// File: tb/rx_rts_flow_bench.sv
module rx_rts_flow_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [6:0] fifo_level = '0;
  logic [1:0] trig_sel = 2'd1;
  logic       auto_en = 0, rts_req = 0, ext_en = 0, ier_wr = 0, ier_rts = 0, stat_rd = 0;
  logic       rts_n, rts_flag, rts_irq;

  int checks = 0, errors = 0;
  bit m_halt = 0, m_rq = 1, m_flag = 0, m_ien = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_rts_flow u_rx_rts_flow (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .trig_sel(trig_sel),
    .auto_en(auto_en), .rts_req(rts_req), .ext_en(ext_en), .ier_wr(ier_wr),
    .ier_rts(ier_rts), .stat_rd(stat_rd), .rts_n(rts_n), .rts_flag(rts_flag),
    .rts_irq(rts_irq));

  function automatic int trig_of(logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 16; 2'd2: return 56; default: return 60; endcase
  endfunction
  function automatic int lo_of(logic [1:0] s); return trig_of(s) / 2; endfunction
  function automatic int hi_of(logic [1:0] s); return 64 - trig_of(s) / 2; endfunction
  function automatic bit pin_of(bit halt); return !rts_req || (auto_en && halt); endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    bit act_now, pin_now, nh, nf;
    act_now = auto_en && rts_req;
    pin_now = pin_of(m_halt);
    if (!act_now) nh = 0;
    else if (fifo_level > hi_of(trig_sel)) nh = 1;
    else if (fifo_level < lo_of(trig_sel)) nh = 0;
    else nh = m_halt;
    if (auto_en && pin_now && !m_rq) nf = 1;
    else if (stat_rd) nf = 0;
    else nf = m_flag;
    if (ier_wr && ext_en) m_ien = ier_rts;
    m_rq = pin_now; m_halt = nh; m_flag = nf;
    @(posedge clk); #1;
    check(tag, rts_n, pin_of(m_halt), "rts_n");
    check(tag, rts_flag, m_flag, "rts_flag");
    check(tag, rts_irq, m_flag & m_ien, "rts_irq");
    @(negedge clk);
    ier_wr = 0; stat_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #1;
    check("R1", rts_n, 1'b1, "rts_n in reset");
    check("R1", rts_flag, 1'b0, "rts_flag in reset");
    check("R1", rts_irq, 1'b0, "rts_irq in reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    step("R1");

    // R2 direct mode
    fifo_level = 7'd64; rts_req = 1; step("R2");
    rts_req = 0; step("R2");
    rts_req = 1; fifo_level = 0; step("R2");

    // R3 armed but not started
    auto_en = 1; rts_req = 0; fifo_level = 7'd64; step("R3"); step("R3");
    fifo_level = 0; step("R3");

    // R10 locked write is ignored, then unlocked write
    ext_en = 0; ier_wr = 1; ier_rts = 1; step("R10");
    ext_en = 1; ier_wr = 1; ier_rts = 1; step("R10");
    ext_en = 0;

    // R7 thresholds for every selection, exact edges
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s); rts_req = 1; fifo_level = 7'(lo_of(trig_sel)); step("R7");
      fifo_level = 7'(hi_of(trig_sel)); step("R6");
      fifo_level = 7'(hi_of(trig_sel) + 1); step("R4");
      step("R8");
      fifo_level = 7'(lo_of(trig_sel)); step("R6");
      fifo_level = 7'(lo_of(trig_sel) - 1); step("R5");
      stat_rd = 1; step("R9");
    end

    // R11 drop request while halted, re-arm
    trig_sel = 2'd1; fifo_level = 7'd60; step("R4");
    rts_req = 0; fifo_level = 7'd30; step("R11");
    rts_req = 1; step("R11");
    fifo_level = 7'd60; step("R4");
    auto_en = 0; step("R11");
    auto_en = 1; step("R11");

    // R9 clear collides with new rise
    fifo_level = 7'd60; stat_rd = 1; step("R9");
    stat_rd = 1; step("R9");
    step("R9");

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      fifo_level = 7'($urandom_range(0, 64));
      if (r < 8) trig_sel = 2'($urandom_range(0, 3));
      if (r < 4) auto_en = ~auto_en;
      if (r >= 95) rts_req = ~rts_req;
      stat_rd = ($urandom_range(0, 9) == 0);
      ext_en = ($urandom_range(0, 3) == 0);
      ier_wr = ($urandom_range(0, 19) == 0);
      ier_rts = 1'($urandom_range(0, 1));
      step("R6");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule